// File: doc/BRIEF.md
# Machine-Cycle Interval Timer with Width Modes

This block measures time intervals in machine cycles, where one machine cycle is twelve clocks. It holds two byte-wide count registers, an upper and a lower one. Software loads a starting value into them, picks a counting width and raises the run enable. The count then climbs once per machine cycle until it passes the all-ones value of the chosen width. On that rollover, a sticky overflow flag is raised.

Three widths are offered. The 13-bit width uses the lower register's five low bits as a divide-by-32 stage below the upper byte. The 16-bit width chains the two bytes. The 8-bit width counts in the lower register and refills it from the upper register on every rollover, so it produces a periodic interval with no software reload. A start value IV gives MAX − IV machine cycles before the count reaches the maximum, and the flag rises on the tick after that, so the interval in clocks is (MAX − IV + 1) × 12.

Top module: `cyc_timer`

## Requirements
- R1: After reset both count registers read 0x00 and the overflow flag is 0.
- R2: While run_en is high, the count advances exactly once every 12 clocks. After reset or after whole runs of 12 clocks, the first 11 enabled clocks leave the count unchanged and the 12th advances it.
- R3: While run_en is low, both the prescale phase and the count registers hold their values, and counting resumes from the same phase.
- R4: Mode code 2'b00 (13-bit): the count is {upper[7:0], lower[4:0]}. A carry out of lower[4:0] increments the upper byte, and lower[7:5] is never changed by counting.
- R5: Mode code 2'b01 (16-bit): the count is {upper, lower}, and it wraps from 0xFFFF to 0x0000.
- R6: Mode code 2'b10 (8-bit reload): only the lower register counts. When it advances from 0xFF it is loaded with the upper register's value, and the upper register is unchanged.
- R7: The overflow flag is set by the same clock edge that moves the count from its maximum (0x1FFF, 0xFFFF or 0xFF). From start value IV the count reaches the maximum after MAX − IV ticks, with the flag still low.
- R8: The overflow flag stays set until ovf_clr is pulsed. If a flag-setting rollover and ovf_clr occur in the same cycle, the flag ends set.
- R9: A write (wr_hi or wr_lo) in the same cycle as a count tick takes priority. The written register takes wr_data, no increment happens in that cycle, and the flag is not set.
- R10: Mode code 2'b11 freezes the count even while ticks occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_en | input | 1 | Enables the prescaler and the count |
| mode | input | 2 | Width mode code (00 13-bit, 01 16-bit, 10 8-bit reload, 11 frozen) |
| wr_hi | input | 1 | Writes wr_data into the upper register |
| wr_lo | input | 1 | Writes wr_data into the lower register |
| wr_data | input | 8 | Write data |
| rd_hi | output | 8 | Upper register value |
| rd_lo | output | 8 | Lower register value |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_clr | input | 1 | Clears the overflow flag |

## Verification
The hardest situation to reach is a rollover in which the prescale tick lines up exactly with a register write or with a flag clear. The bench reaches it by always running the prescaler in whole 12-clock blocks. This keeps the phase known, so it can assert the write or the clear on precisely the eleventh-plus-one enabled clock. The two rollover widths that are quick to reach are swept over many start values. Each expected count is computed as maximum minus start.

// File: rtl/cyc_timer_pkg.sv
package cyc_timer_pkg;
   typedef enum logic [1:0] {
      MODE_W13  = 2'b00,
      MODE_W16  = 2'b01,
      MODE_W8R  = 2'b10,
      MODE_HOLD = 2'b11
   } tmode_e;
endpackage

// File: rtl/cyc_timer_prescale.sv
module cyc_timer_prescale #(
   parameter int DIV = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_en,
   output logic tick
);
   localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [PW-1:0] LAST = PW'(DIV - 1);

   if (DIV < 2) begin : g_bad_div
      $error("cyc_timer_prescale: DIV must be at least 2");
   end

   logic [PW-1:0] phase;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase <= '0;
      else if (run_en)
         phase <= (phase == LAST) ? '0 : phase + 1'b1;
   end

   assign tick = run_en && (phase == LAST);

   AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> $stable(phase)); // R3
   AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R2
endmodule

// File: rtl/cyc_timer_count.sv
module cyc_timer_count
   import cyc_timer_pkg::*;
#(
   parameter int REG_W  = 8,
   parameter int SUB_W  = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  tmode_e           mode,
   input  logic             wr_hi,
   input  logic             wr_lo,
   input  logic [REG_W-1:0] wr_data,
   input  logic             ovf_clr,
   output logic [REG_W-1:0] hi,
   output logic [REG_W-1:0] lo,
   output logic             ovf_flag
);
   if (SUB_W < 1 || SUB_W >= REG_W) begin : g_bad_sub
      $error("cyc_timer_count: SUB_W must lie in 1..REG_W-1");
   end

   logic [REG_W-1:0] nxt_hi, nxt_lo;
   logic [SUB_W-1:0] sub_inc;
   logic             wrap;
   logic             any_wr;

   assign any_wr  = wr_hi | wr_lo;
   assign sub_inc = lo[SUB_W-1:0] + 1'b1;

   always_comb begin
      nxt_hi = hi;
      nxt_lo = lo;
      wrap   = 1'b0;
      unique case (mode)
         MODE_W13: begin
            nxt_lo[SUB_W-1:0] = sub_inc;
            if (&lo[SUB_W-1:0]) begin
               nxt_hi = hi + 1'b1;
               wrap   = &hi;
            end
         end
         MODE_W16: begin
            {nxt_hi, nxt_lo} = {hi, lo} + 1'b1;
            wrap             = &{hi, lo};
         end
         MODE_W8R: begin
            if (&lo) begin
               nxt_lo = hi;
               wrap   = 1'b1;
            end else begin
               nxt_lo = lo + 1'b1;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi <= '0;
         lo <= '0;
      end else if (any_wr) begin
         if (wr_hi) hi <= wr_data;
         if (wr_lo) lo <= wr_data;
      end else if (tick) begin
         hi <= nxt_hi;
         lo <= nxt_lo;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ovf_flag <= 1'b0;
      else if (tick && !any_wr && wrap)
         ovf_flag <= 1'b1;
      else if (ovf_clr)
         ovf_flag <= 1'b0;
   end

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_flag && !ovf_clr |=> ovf_flag); // R8
   AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> lo == $past(wr_data)); // R9
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tick && !any_wr |=> $stable(hi) && $stable(lo)); // R3
   AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      tick && !any_wr && mode == MODE_W8R && (&lo) |=> lo == $past(hi) && ovf_flag); // R6
   AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      mode == MODE_HOLD && !any_wr |=> $stable(hi) && $stable(lo)); // R10
   AST_SUB_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
      mode == MODE_W13 && !wr_lo |=> $stable(lo[REG_W-1:SUB_W])); // R4
endmodule

// File: rtl/cyc_timer.sv
module cyc_timer
   import cyc_timer_pkg::*;
#(
   parameter int DIV   = 12,
   parameter int REG_W = 8,
   parameter int SUB_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_en,
   input  logic [1:0]       mode,
   input  logic             wr_hi,
   input  logic             wr_lo,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_hi,
   output logic [REG_W-1:0] rd_lo,
   output logic             ovf_flag,
   input  logic             ovf_clr
);
   logic tick;

   cyc_timer_prescale #(.DIV(DIV)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_en (run_en),
      .tick   (tick)
   );

   cyc_timer_count #(.REG_W(REG_W), .SUB_W(SUB_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .mode     (tmode_e'(mode)),
      .wr_hi    (wr_hi),
      .wr_lo    (wr_lo),
      .wr_data  (wr_data),
      .ovf_clr  (ovf_clr),
      .hi       (rd_hi),
      .lo       (rd_lo),
      .ovf_flag (ovf_flag)
   );

   AST_NO_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en && !wr_hi && !wr_lo |=> $stable(rd_hi) && $stable(rd_lo)); // R3
endmodule

// File: tb/cyc_timer_bench.sv
module cyc_timer_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       run_en = 1'b0;
   logic [1:0] mode = 2'b01;
   logic       wr_hi = 1'b0, wr_lo = 1'b0, ovf_clr = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_hi, rd_lo;
   logic       ovf_flag;
   int         n_chk = 0, n_bad = 0;
   bit         done = 1'b0;

   always #5 clk = ~clk;

   cyc_timer u_cyc_timer (
      .clk(clk), .rst_n(rst_n), .run_en(run_en), .mode(mode),
      .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
      .rd_hi(rd_hi), .rd_lo(rd_lo), .ovf_flag(ovf_flag), .ovf_clr(ovf_clr)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic put(bit upper, logic [7:0] d);
      wr_hi = upper; wr_lo = !upper; wr_data = d;
      @(negedge clk);
      wr_hi = 1'b0; wr_lo = 1'b0;
   endtask

   task automatic load(logic [1:0] m, logic [7:0] h, logic [7:0] l);
      mode = m;
      put(1'b1, h);
      put(1'b0, l);
   endtask

   task automatic clr_flag();
      ovf_clr = 1'b1;
      @(negedge clk);
      ovf_clr = 1'b0;
   endtask

   task automatic run(int clocks);
      run_en = 1'b1;
      repeat (clocks) @(negedge clk);
      run_en = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", {rd_hi, rd_lo, 7'd0, ovf_flag}, 32'h0);

      // R2 prescale: 11 clocks no change, 12th advances (16-bit mode)
      load(2'b01, 8'h12, 8'h34);
      run(11);
      check("R2", {rd_hi, rd_lo}, 16'h1234);
      run(1);
      check("R2", {rd_hi, rd_lo}, 16'h1235);

      // R3 partial phase held across idle
      run(6);
      check("R3", {rd_hi, rd_lo}, 16'h1235);
      repeat (40) @(negedge clk);
      check("R3", {rd_hi, rd_lo}, 16'h1235);
      run(6);
      check("R3", {rd_hi, rd_lo}, 16'h1236);

      // R5 16-bit byte carry and wrap, R7 flag timing
      load(2'b01, 8'h00, 8'hFF);
      run(12);
      check("R5", {rd_hi, rd_lo}, 16'h0100);
      load(2'b01, 8'hFF, 8'hFD);
      run(24);
      check("R7", {rd_hi, rd_lo, 7'd0, ovf_flag}, {16'hFFFF, 8'h00});
      run(12);
      check("R5", {rd_hi, rd_lo, 7'd0, ovf_flag}, {16'h0000, 8'h01});
      // R8 sticky
      run(36);
      check("R8", ovf_flag, 1);
      clr_flag();
      check("R8", ovf_flag, 0);

      // R4 13-bit carry into upper, upper lower bits kept
      load(2'b00, 8'h12, 8'hFF);
      run(12);
      check("R4", {rd_hi, rd_lo, 7'd0, ovf_flag}, {8'h13, 8'hE0, 8'h00});

      // R4/R7 sweep of 13-bit rollover from every sub-count
      for (int v = 0; v < 32; v++) begin
         load(2'b00, 8'hFF, 8'hA0 | 8'(v));
         clr_flag();
         run((31 - v) * 12);
         check("R7", {rd_hi, rd_lo, 7'd0, ovf_flag}, {8'hFF, 8'hBF, 8'h00});
         run(12);
         check("R4", {rd_hi, rd_lo, 7'd0, ovf_flag}, {8'h00, 8'hA0, 8'h01});
      end

      // R6/R7 sweep of 8-bit reload mode
      for (int r = 0; r < 256; r += 17) begin
         load(2'b10, 8'(r), 8'(r));
         clr_flag();
         run((255 - r) * 12);
         check("R7", {rd_hi, rd_lo, 7'd0, ovf_flag}, {8'(r), 8'hFF, 8'h00});
         run(12);
         check("R6", {rd_hi, rd_lo, 7'd0, ovf_flag}, {8'(r), 8'(r), 8'h01});
      end

      // R8 set wins over clear in same cycle
      load(2'b10, 8'h40, 8'hFF);
      clr_flag();
      run_en = 1'b1;
      repeat (11) @(negedge clk);
      ovf_clr = 1'b1;
      @(negedge clk);
      ovf_clr = 1'b0; run_en = 1'b0;
      check("R8", {rd_lo, 7'd0, ovf_flag}, {8'h40, 8'h01});
      clr_flag();

      // R9 write on tick cycle wins, no flag
      load(2'b10, 8'h40, 8'hFF);
      run_en = 1'b1;
      repeat (11) @(negedge clk);
      wr_lo = 1'b1; wr_data = 8'h55;
      @(negedge clk);
      wr_lo = 1'b0; run_en = 1'b0;
      check("R9", {rd_hi, rd_lo, 7'd0, ovf_flag}, {8'h40, 8'h55, 8'h00});
      run(12);
      check("R9", rd_lo, 8'h56);

      // R10 frozen mode
      load(2'b11, 8'hFF, 8'hFF);
      run(60);
      check("R10", {rd_hi, rd_lo, 7'd0, ovf_flag}, {16'hFFFF, 8'h00});

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule